// File: doc/BRIEF.md
# Receive Event Ring with Edge-Gated Interrupt

This block holds incoming device events in a ring of slots until a CPU drains them. The device side presents an event with a valid strobe. Each slot carries an occupied flag. An event is accepted only when the slot under the write pointer is free. Otherwise the event is thrown away and a saturating loss counter records it. The CPU sees the oldest pending entry directly at the read side. It retires that entry with a single-cycle strobe.

The interrupt line is level-sensitive, and it is raised only when the ring passes from holding nothing to holding something. A burst of arrivals therefore costs the CPU one interrupt and not one per event. The CPU clears the line with an acknowledge. If entries are still pending when the acknowledge lands, the line drops for one cycle and then rises again, so that pending work is not left without a request. The loss counter can be read and cleared at any time.

Top module: `evq_irq_ring`

## Requirements
- R1: One cycle after an event is accepted into an empty ring, `irq` is 1. Accepting an event while entries are already pending creates no new interrupt.
- R2: An event that arrives while the slot at the write pointer is occupied (the ring holds DEPTH entries) is discarded. The pending entries and their order are left unchanged.
- R3: An accepted event is stored in the slot at the write pointer. Entries are presented on `head_data`, with `head_valid` = 1, in arrival order.
- R4: The write and read pointers each advance by one slot per accepted event or retired entry, and they wrap from DEPTH-1 to 0. Order is preserved across the wrap.
- R5: `irq` is a level. Once high, it stays high until a cycle with `irq_ack` = 1. An `irq_ack` while `irq` is low has no effect.
- R6: `cpu_retire` removes the head entry only when that slot is occupied. A retire on an empty ring changes nothing.
- R7: An acknowledge that leaves entries pending drives `irq` low for exactly one cycle, and it rises again the next cycle if entries are still pending then. An acknowledge that leaves the ring empty returns `irq` to idle.
- R8: `drop_count` is 16 bits wide. It increments by one per discarded event and saturates at 65535. `drop_clear` sets it to 0. A clear and a discard in the same cycle leave it at 1.
- R9: A push and a retire in the same cycle both take effect. On a full ring, a retire does not let a push in the same cycle take the slot being freed, so that push is discarded.
- R10: While reset is applied and after it is released, `irq` = 0, `head_valid` = 0 and `drop_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Event present this cycle |
| ev_data | input | DATA_W | Event payload |
| cpu_retire | input | 1 | Retire the head entry |
| head_valid | output | 1 | Head slot holds a pending entry |
| head_data | output | DATA_W | Payload of the head entry |
| irq_ack | input | 1 | CPU acknowledge of the interrupt |
| irq | output | 1 | Level-sensitive interrupt request |
| drop_clear | input | 1 | Clear the loss counter |
| drop_count | output | CNT_W | Saturating count of discarded events |

## Verification
The bench attacks four corner cases.

- **Push into a full ring while the head retires.** A design that lets the push reuse the freed slot would overwrite the oldest entry or repeat one.
- **Acknowledge with entries still pending.** A design that clears the line for good strands events. One that never drops the line hides the new request edge.
- **Burst into an empty ring.** This exposes a design that raises a fresh request per event or loses the first one.
- **Loss counter at its ceiling, and cleared while a discard arrives.** This catches wrap-around and a dropped count.

A long mixed phase moves both pointers past the wrap many times while acknowledges arrive at random points.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // Interrupt line states: idle, raised, and the one-cycle gap after an
  // acknowledge that left entries pending.
  typedef enum logic [1:0] {
    IRQ_IDLE  = 2'd0,
    IRQ_HIGH  = 2'd1,
    IRQ_REARM = 2'd2
  } irq_state_e;

endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/evq_slot_store.sv
module evq_slot_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_occ,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic              probe_occ,
  output logic              occ_any,
  output logic              occ_any_next
);

  logic [DEPTH-1:0]  occ_q, occ_d;
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic set_i, clr_i;
    assign set_i = wr_en  && (wr_idx  == IDX_W'(i));
    assign clr_i = clr_en && (clr_idx == IDX_W'(i));

    always_comb begin
      occ_d[i] = (occ_q[i] & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
      if (set_i) data_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign rd_data      = data_q[rd_idx];
  assign rd_occ       = occ_q[rd_idx];
  assign probe_occ    = occ_q[probe_idx];
  assign occ_any      = |occ_q;
  assign occ_any_next = |occ_d;

  // A write must land in a free slot, so no pending entry is ever overwritten.
  assert_no_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !occ_q[wr_idx]);

  // A slot is cleared only while it holds an entry.
  assert_clear_occupied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> occ_q[clr_idx]);

  // A written slot reads back as occupied, with its payload, on the next cycle.
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> occ_q[$past(wr_idx)] && (data_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/evq_ptr_ctrl.sv
module evq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             retire,
  input  logic             tail_occ,
  input  logic             head_occ,
  output logic             push_ok,
  output logic             drop,
  output logic             pop_ok,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head
);

  if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
    $error("evq_ptr_ctrl: DEPTH must be a power of two");
  end

  logic [IDX_W-1:0] tail_q, tail_d, head_q, head_d;

  // The tail flag is the registered one, so a retire in the same cycle
  // cannot free the slot for this push.
  always_comb begin
    push_ok = ev_valid && !tail_occ;
    drop    = ev_valid &&  tail_occ;
    pop_ok  = retire   &&  head_occ;
    tail_d  = tail_q;
    head_d  = head_q;
    if (push_ok) tail_d = tail_q + IDX_W'(1);
    if (pop_ok)  head_d = head_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
    end else begin
      tail_q <= tail_d;
      head_q <= head_d;
    end
  end

  assign tail = tail_q;
  assign head = head_q;

  assert_tail_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> tail_q == $past(tail_q) + IDX_W'(1));

  assert_head_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> head_q == $past(head_q) + IDX_W'(1));

  assert_drop_holds_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(tail_q));

  assert_empty_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !head_occ) |=> $stable(head_q));

endmodule

// File: rtl/evq_drop_ctr.sv
module evq_drop_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             cnt_en;

  always_comb begin
    base   = clear ? '0 : cnt_q;
    cnt_en = clear || drop;
    cnt_d  = base;
    if (drop && (base != CNT_MAX)) cnt_d = base + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clear) |=> cnt_q == CNT_MAX);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !drop) |=> cnt_q == '0);

endmodule

// File: rtl/evq_irq_gen.sv
module evq_irq_gen
  import evq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_ok,
  input  logic occ_any,
  input  logic occ_any_next,
  input  logic ack,
  output logic irq
);

  irq_state_e st_q, st_d;
  logic       rise;

  assign rise = push_ok && !occ_any;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      IRQ_IDLE:  if (rise) st_d = IRQ_HIGH;
      IRQ_HIGH:  if (ack && !rise) st_d = occ_any_next ? IRQ_REARM : IRQ_IDLE;
      IRQ_REARM: st_d = occ_any_next ? IRQ_HIGH : IRQ_IDLE;
      default:   st_d = IRQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= IRQ_IDLE;
    else        st_q <= st_d;
  end

  assign irq = (st_q == IRQ_HIGH);

  assert_rise_on_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> irq);

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);

  assert_ack_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack && !rise) |=> !irq);

  assert_rise_needs_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> occ_any);

endmodule

// File: rtl/evq_irq_ring.sv
module evq_irq_ring #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              cpu_retire,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data,
  input  logic              irq_ack,
  output logic              irq,
  input  logic              drop_clear,
  output logic [CNT_W-1:0]  drop_count
);

  localparam int IDX_W = $clog2(DEPTH);

  logic             rst_n_s;
  logic             push_ok, drop, pop_ok;
  logic [IDX_W-1:0] tail, head;
  logic             tail_occ, head_occ, occ_any, occ_any_next;

  evq_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  evq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ev_valid (ev_valid),
    .retire   (cpu_retire),
    .tail_occ (tail_occ),
    .head_occ (head_occ),
    .push_ok  (push_ok),
    .drop     (drop),
    .pop_ok   (pop_ok),
    .tail     (tail),
    .head     (head)
  );

  evq_slot_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wr_en        (push_ok),
    .wr_idx       (tail),
    .wr_data      (ev_data),
    .clr_en       (pop_ok),
    .clr_idx      (head),
    .rd_idx       (head),
    .rd_data      (head_data),
    .rd_occ       (head_occ),
    .probe_idx    (tail),
    .probe_occ    (tail_occ),
    .occ_any      (occ_any),
    .occ_any_next (occ_any_next)
  );

  evq_drop_ctr #(.CNT_W(CNT_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n_s),
    .drop  (drop),
    .clear (drop_clear),
    .count (drop_count)
  );

  evq_irq_gen u_irq (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .push_ok      (push_ok),
    .occ_any      (occ_any),
    .occ_any_next (occ_any_next),
    .ack          (irq_ack),
    .irq          (irq)
  );

  assign head_valid = head_occ;

  // A full ring never accepts, even with a retire in the same cycle.
  assert_full_blocks_push_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ev_valid && tail_occ) |=> drop_count != '0);

endmodule

// File: tb/tb_evq_irq_ring.sv
module tb_evq_irq_ring;

  localparam int CLK_P  = 10;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ev_valid, cpu_retire, irq_ack, drop_clear;
  logic [DATA_W-1:0] ev_data;
  logic              head_valid, irq;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  drop_count;

  int    checks = 0;
  int    errors = 0;
  bit    chk_en = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R10";

  // Reference model state.
  logic [DATA_W-1:0] mq[$];
  int m_irq;          // 0 idle, 1 raised, 2 gap after acknowledge
  int m_drop;
  int sz, nxt, base;
  bit m_push, m_pop, m_rise, m_lost;

  always #(CLK_P/2) clk = ~clk;

  evq_irq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_data    (ev_data),
    .cpu_retire (cpu_retire),
    .head_valid (head_valid),
    .head_data  (head_data),
    .irq_ack    (irq_ack),
    .irq        (irq),
    .drop_clear (drop_clear),
    .drop_count (drop_count)
  );

  task automatic check_eq(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // Model step at each edge, then compare away from the edge.
  always @(posedge clk) begin
    if (chk_en) begin
      sz     = mq.size();
      m_push = ev_valid && (sz < DEPTH);
      m_lost = ev_valid && !m_push;
      m_pop  = cpu_retire && (sz > 0);
      m_rise = m_push && (sz == 0);
      if (m_pop)  void'(mq.pop_front());
      if (m_push) mq.push_back(ev_data);
      nxt = mq.size();
      case (m_irq)
        0: if (m_rise) m_irq = 1;
        1: if (irq_ack && !m_rise) m_irq = (nxt > 0) ? 2 : 0;
        default: m_irq = (nxt > 0) ? 1 : 0;
      endcase
      base = drop_clear ? 0 : m_drop;
      if (m_lost && base < CMAX) base++;
      m_drop = base;
      #2;
      check_eq("head_valid", 64'(head_valid), 64'(mq.size() > 0));
      if (mq.size() > 0) check_eq("head_data", 64'(head_data), 64'(mq[0]));
      check_eq("irq", 64'(irq), 64'(m_irq == 1));
      check_eq("drop_count", 64'(drop_count), 64'(m_drop));
    end
  end

  task automatic cyc(bit v, logic [DATA_W-1:0] d, bit r, bit a, bit c);
    @(negedge clk);
    ev_valid = v; ev_data = d; cpu_retire = r; irq_ack = a; drop_clear = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ev_valid = 0; ev_data = '0; cpu_retire = 0; irq_ack = 0; drop_clear = 0;
    m_irq = 0; m_drop = 0;
    repeat (3) @(negedge clk);
    cur_req = "R10";  // outputs held at reset values
    check_eq("irq in reset", 64'(irq), 64'(0));
    check_eq("head_valid in reset", 64'(head_valid), 64'(0));
    check_eq("drop_count in reset", 64'(drop_count), 64'(0));
    chk_en = 1'b1;
    rst_n  = 1'b1;
    idle(4);

    cur_req = "R6";   // retire and stray acknowledge on an empty ring
    cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 1, 1, 0);
    idle(1);

    cur_req = "R1";   // first event raises, following ones do not
    cyc(1, 32'hA001, 0, 0, 0);
    cyc(1, 32'hA002, 0, 0, 0);
    cyc(1, 32'hA003, 0, 0, 0);
    cur_req = "R5";   // level held without acknowledge
    idle(5);
    cur_req = "R7";   // acknowledge with pending entries: gap then re-raise
    cyc(0, '0, 0, 1, 0);
    idle(3);
    cur_req = "R3";   // drain in order
    cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 1, 0, 0);
    idle(2);
    cur_req = "R7";   // acknowledge on empty ring returns to idle
    cyc(0, '0, 0, 1, 0);
    idle(3);

    cur_req = "R2";   // fill and overflow
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 32'hB000 + DATA_W'(i), 0, 0, 0);
    idle(2);
    cur_req = "R9";   // full: retire with push, push must be lost
    cyc(1, 32'hC001, 1, 0, 0);
    cyc(1, 32'hC002, 1, 0, 0);  // now non-full: both take effect
    cyc(1, 32'hC003, 1, 1, 0);
    idle(2);

    cur_req = "R4";   // mixed traffic across many wraps
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 3) != 0, $urandom, ($urandom % 2) == 0, ($urandom % 5) == 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, '0, 1, 1, 0);
    idle(2);

    cur_req = "R8";   // clear, clear with loss, saturation
    cyc(0, '0, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'hD000 + DATA_W'(i), 0, 0, 0);
    cyc(1, 32'hDEAD, 0, 0, 1);
    idle(1);
    for (int i = 0; i < CMAX + 5; i++) cyc(1, 32'hE000, 0, 0, 0);
    idle(2);
    cyc(0, '0, 0, 0, 1);
    idle(2);

    chk_en = 1'b0;
    finish_run();
  end

endmodule